// File: doc/BRIEF.md
# Masked Data-Bus Break Comparator

This block is one debug break channel. It watches each CPU data-bus transfer and raises a one-clock break-match pulse when the transferred data equals a programmed break value. Bits can be removed from the compare through a per-bit mask. The comparison is also qualified by the transfer size, so a break fires only for transfers of the programmed operand size.

A small write port loads three registers: the break value, the mask and a control word. The control word holds the operand size, a dual-bus enable and a dual-bus select. The compare window depends on that mode. Without the dual-bus enable, all 32 bits are compared. With it, either only the upper half (X data) or only the lower half (Y data) is compared. Byte compares look at a single byte lane chosen by the parity of the address. Any bit outside the active window counts as matching.

There are two reset inputs. A power-on reset clears every register. A manual reset leaves the registers as they are and only silences the match output.

Top module: `data_break_cmp`

## Requirements
- R1: While `por_n` is low, at the next clock edge the break value and mask are cleared to zero, the control word becomes size code 2'b11 (compare disabled) with both dual-bus bits 0, and `match` is 0.
- R2: While `mrst_n` is low and `por_n` is high, the registers keep their contents, writes are ignored, and `match` is 0 at the next edge.
- R3: When `wr_en` is high at a clock edge outside reset, `wr_addr` selects the target. 0 selects the break value, 1 selects the mask, and 2 selects the control word, with size in bits 1:0, dual-bus enable in bit 2 and dual-bus select in bit 3. Address 3 is ignored.
- R4: `match` is registered. It is high in the clock after the edge that samples a qualifying transfer with `bus_valid` high, for exactly one clock per transfer. It is 0 when `bus_valid` is low.
- R5: A mask bit of 1 removes that data bit from the compare. A mask bit of 0 keeps it in the compare.
- R6: For word (2'b01) or longword (2'b10) size with the dual-bus enable 0, all 32 bits are compared.
- R7: With the dual-bus enable 1 and select 0, only bits 31:16 are compared. Bits 15:0 are ignored.
- R8: With the dual-bus enable 1 and select 1, only bits 15:0 are compared. Bits 31:16 are ignored.
- R9: For byte size (2'b00), only bits 7:0 are compared when `bus_addr[0]` is 1, and only bits 15:8 when it is 0. This holds whatever the dual-bus bits are.
- R10: A match requires `bus_size` to equal the programmed size. A programmed size of 2'b11 never matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, synchronous |
| mrst_n | input | 1 | Manual reset, active low, synchronous |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select |
| wr_data | input | 32 | Register write data |
| bus_valid | input | 1 | Transfer valid strobe |
| bus_addr | input | ADDR_W | Transfer address |
| bus_size | input | 2 | Transfer size: 00 byte, 01 word, 10 longword |
| bus_data | input | 32 | Transfer data |
| match | output | 1 | Registered break-match pulse |

## Verification
A transfer presented before a clock edge shows up on `match` one cycle later. A register write takes effect at the edge that samples it, so it governs a transfer presented in the following cycle. The bench changes inputs only on falling edges. It reads `match` at the falling edge that follows the sampling rising edge, and reads it once more a cycle later to confirm the pulse lasts a single clock. Reset effects are checked the same way: the reset is held over one rising edge and the result is observed at the next falling edge.

// File: rtl/data_break_cmp.sv
module data_break_cmp #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              mrst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              bus_valid,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [1:0]        bus_size,
  input  logic [DATA_W-1:0] bus_data,
  output logic              match
);
  localparam int HALF = DATA_W / 2;
  localparam logic [1:0] SZ_BYTE = 2'b00;
  localparam logic [1:0] SZ_OFF  = 2'b11;
  localparam logic [DATA_W-1:0] WIN_ALL  = {DATA_W{1'b1}};
  localparam logic [DATA_W-1:0] WIN_HI   = {{HALF{1'b1}}, {HALF{1'b0}}};
  localparam logic [DATA_W-1:0] WIN_LO   = {{HALF{1'b0}}, {HALF{1'b1}}};
  localparam logic [DATA_W-1:0] WIN_ODD  = {{(DATA_W-8){1'b0}}, 8'hFF};
  localparam logic [DATA_W-1:0] WIN_EVEN = {{(DATA_W-16){1'b0}}, 8'hFF, 8'h00};

  logic [DATA_W-1:0] brk_data, brk_mask, win;
  logic [1:0]        ctl_size;
  logic              ctl_xy_en, ctl_xy_sel;
  logic              run, hit, size_ok;

  assign run = por_n && mrst_n;

  always_ff @(posedge clk) begin
    if (!por_n) begin
      brk_data   <= '0;
      brk_mask   <= '0;
      ctl_size   <= SZ_OFF;
      ctl_xy_en  <= 1'b0;
      ctl_xy_sel <= 1'b0;
    end else if (mrst_n && wr_en) begin
      case (wr_addr)
        2'd0: brk_data <= wr_data;
        2'd1: brk_mask <= wr_data;
        2'd2: begin
          ctl_size   <= wr_data[1:0];
          ctl_xy_en  <= wr_data[2];
          ctl_xy_sel <= wr_data[3];
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    if (ctl_size == SZ_BYTE)
      win = bus_addr[0] ? WIN_ODD : WIN_EVEN;
    else if (!ctl_xy_en)
      win = WIN_ALL;
    else
      win = ctl_xy_sel ? WIN_LO : WIN_HI;
  end

  assign size_ok = (ctl_size != SZ_OFF) && (bus_size == ctl_size);
  assign hit     = &(~win | brk_mask | ~(bus_data ^ brk_data));

  always_ff @(posedge clk) begin
    if (!run) match <= 1'b0;
    else      match <= bus_valid && size_ok && hit;
  end

  AST_POR_CLEAR: assert property (@(posedge clk)
    !por_n |=> (brk_mask == '0) && (brk_data == '0) && (ctl_size == SZ_OFF) && !match); // R1
  AST_MRST_HOLD: assert property (@(posedge clk) disable iff (!por_n)
    !mrst_n |=> $stable(brk_mask) && $stable(brk_data) && $stable(ctl_size) && !match); // R2
  AST_MATCH_VALID: assert property (@(posedge clk) disable iff (!por_n)
    match |-> $past(bus_valid) && $past(run)); // R4
  AST_MATCH_SIZE: assert property (@(posedge clk) disable iff (!por_n)
    match |-> ($past(bus_size) == $past(ctl_size)) && ($past(ctl_size) != SZ_OFF)); // R10
  AST_MASKED_FREE: assert property (@(posedge clk) disable iff (!por_n)
    (run && bus_valid && size_ok && (brk_mask == WIN_ALL)) |=> match); // R5
endmodule

// File: tb/tb_data_break_cmp.sv
module tb_data_break_cmp;
  logic clk = 0, por_n = 0, mrst_n = 1, wr_en = 0, bus_valid = 0;
  logic [1:0] wr_addr = 0, bus_size = 0;
  logic [31:0] wr_data = 0, bus_addr = 0, bus_data = 0;
  logic match;
  int checks = 0, errors = 0;
  bit done = 0;

  data_break_cmp dut (.clk(clk), .por_n(por_n), .mrst_n(mrst_n), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .bus_valid(bus_valid), .bus_addr(bus_addr),
    .bus_size(bus_size), .bus_data(bus_data), .match(match));

  always #5 clk = ~clk;

  task automatic chk(input logic act, input logic exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: match=%0b expected %0b", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic xfer(input logic [31:0] d, input logic a0, input logic [1:0] sz,
                      input logic v, input logic exp, input string req);
    @(negedge clk); bus_valid = v; bus_data = d; bus_addr = {31'd0, a0}; bus_size = sz;
    @(negedge clk); chk(match, exp, req); bus_valid = 0;
  endtask

  task automatic t_reset();
    @(negedge clk); chk(match, 0, "R1 reset match");
    xfer(32'h0, 0, 2'b10, 1, 0, "R1 size disabled after power-on");
  endtask

  task automatic t_long();
    wr(0, 32'h12345678); wr(2, 32'h2);
    xfer(32'h12345678, 0, 2'b10, 1, 1, "R6 longword equal");
    @(negedge clk); chk(match, 0, "R4 single pulse");
    xfer(32'h12345679, 0, 2'b10, 1, 0, "R6 bit0 differs");
    xfer(32'h12345678, 0, 2'b10, 0, 0, "R4 valid low");
    xfer(32'h12345678, 0, 2'b01, 1, 0, "R10 size mismatch");
  endtask

  task automatic t_mask();
    wr(1, 32'h0000000F);
    xfer(32'h1234567A, 0, 2'b10, 1, 1, "R5 masked nibble");
    xfer(32'h1234667A, 0, 2'b10, 1, 0, "R5 unmasked bit differs");
    wr(3, 32'h0);
    xfer(32'h1234567A, 0, 2'b10, 1, 1, "R3 addr 3 ignored");
    wr(1, 32'h0);
  endtask

  task automatic t_xy();
    wr(2, 32'h5);
    xfer(32'h1234FFFF, 0, 2'b01, 1, 1, "R7 X upper compared");
    xfer(32'h12355678, 0, 2'b01, 1, 0, "R7 X upper differs");
    xfer(32'h1234FFFF, 0, 2'b10, 1, 0, "R10 X size mismatch");
    wr(2, 32'hD);
    xfer(32'hFFFF5678, 0, 2'b01, 1, 1, "R8 Y lower compared");
    xfer(32'h12345679, 0, 2'b01, 1, 0, "R8 Y lower differs");
  endtask

  task automatic t_byte();
    wr(0, 32'h0000A55A); wr(2, 32'hC);
    xfer(32'hFFFFFF5A, 1, 2'b00, 1, 1, "R9 odd lane");
    xfer(32'hFFFFFF5B, 1, 2'b00, 1, 0, "R9 odd lane differs");
    xfer(32'hFFFFA5FF, 0, 2'b00, 1, 1, "R9 even lane");
    xfer(32'hFFFF5AFF, 0, 2'b00, 1, 0, "R9 even lane differs");
    wr(2, 32'h3);
    xfer(32'h0000A55A, 1, 2'b11, 1, 0, "R10 size off");
  endtask

  task automatic t_mrst();
    wr(0, 32'hCAFEF00D); wr(2, 32'h2);
    @(negedge clk); mrst_n = 0; wr_en = 1; wr_addr = 0; wr_data = 32'h0;
    bus_valid = 1; bus_data = 32'hCAFEF00D; bus_size = 2'b10;
    @(negedge clk); chk(match, 0, "R2 match low in manual reset");
    mrst_n = 1; wr_en = 0; bus_valid = 0;
    xfer(32'hCAFEF00D, 0, 2'b10, 1, 1, "R2 registers kept");
  endtask

  task automatic t_por();
    wr(1, 32'hFFFFFFFF); wr(0, 32'h11111111);
    @(negedge clk); por_n = 0;
    @(negedge clk); por_n = 1;
    wr(2, 32'h2);
    xfer(32'h00000000, 0, 2'b10, 1, 1, "R1 data cleared");
    xfer(32'h00000001, 0, 2'b10, 1, 0, "R1 mask cleared");
  endtask

  initial begin
    repeat (2) @(negedge clk);
    por_n = 1;
    t_reset(); t_long(); t_mask(); t_xy(); t_byte(); t_mrst(); t_por();
    done = 1;
  end

  initial begin
    for (int i = 0; i < 5000 && !done; i++) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: done=0 expected 1");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule